// File: doc/BRIEF.md
# Timed Transmit Packet Release Gate

This block sits at the head of a transmit packet queue and decides, for each packet sent by the host, when its samples go to the DAC pipeline. Each packet arrives as a stream of 32-bit words. The first word carries control flags. The second word carries the 32-bit sample time at which the first sample should play. Every word after that, up to the word marked as the end of the packet, is a sample. The gate compares the packet's time with a free-running 32-bit sample-time counter. It then holds the packet until that time, plays it at once, or throws it away as late.

The gate also follows burst boundaries. A burst opens with a start-flagged packet and closes when an end-flagged packet finishes. A sample strobe that finds the queue empty counts as an underrun only while a burst is open. Gaps between bursts are expected and are not reported.

The controller has five states:
- `ST_IDLE` waits for a header word.
- `ST_STAMP` takes the time word and chooses what to do with the packet.
- `ST_HOLD` waits for the packet's time.
- `ST_PLAY` forwards one sample per strobe.
- `ST_FLUSH` discards the rest of a late packet.

Transitions:
- IDLE→STAMP when a start-marked word is accepted.
- STAMP→PLAY when the verdict is "now".
- STAMP→HOLD when the verdict is "wait".
- STAMP→FLUSH when the verdict is "late".
- STAMP→IDLE when the packet ends on its time word.
- HOLD→PLAY when the counter equals the packet's time.
- HOLD→FLUSH when the counter has moved past the packet's time.
- HOLD→IDLE, PLAY→IDLE and FLUSH→IDLE when the end-marked word is consumed.

Top module: `tx_release_gate`

## Requirements
- R1: After reset, `out_valid`, `drop_pulse` and `underrun_pulse` are low, `in_ready` is high, and no burst is open.
- R2: A packet is a header word marked by `in_sop`, then a time word, then at least one sample word, with `in_eop` on the last word. Header bit 2 requests immediate play, bit 1 opens a burst, and bit 0 closes the burst once the packet's last word is consumed.
- R3: A packet whose time is in the future outputs nothing until the counter reaches its time. Its first sample leaves on the first strobe for which `now_time` equals the packet time. Future is decided by the sign of (time − now) taken modulo 2^32, so the comparison still works when the counter wraps.
- R4: A packet whose time has already passed, meaning (time − now) is negative as a 32-bit value, outputs no samples. `drop_pulse` is high for exactly one cycle. The packet is consumed at one word per clock whatever the strobe does, so a packet with N samples takes N+2 cycles.
- R5: A time word of 0xFFFFFFFF plays the packet at once, with no time comparison.
- R6: A packet with the immediate bit set plays at once even if its time has passed, and it is not dropped.
- R7: While a packet plays, exactly one sample goes out on each strobe for which a word is available, the samples come out in arrival order, and no sample goes out without a strobe.
- R8: While a burst is open, a strobe that finds no input word available raises `underrun_pulse` for that cycle. This applies inside a packet and between packets.
- R9: A strobe that finds no input word does not raise `underrun_pulse` outside a burst. That covers the time after an end-flagged packet and packets that belong to no burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 32 | Packet word from the queue head |
| in_valid | input | 1 | `in_data` holds a word |
| in_sop | input | 1 | Word is a packet header |
| in_eop | input | 1 | Word is the packet's last word |
| in_ready | output | 1 | Gate consumes the word this cycle |
| now_time | input | 32 | Free-running sample-time counter |
| smp_strobe | input | 1 | Sample slot for the DAC pipeline |
| out_sample | output | 32 | Sample word to the DAC pipeline |
| out_valid | output | 1 | `out_sample` is valid this cycle |
| drop_pulse | output | 1 | One-cycle pulse when a late packet is discarded |
| underrun_pulse | output | 1 | Strobe found the queue empty inside a burst |

## Verification
The checker module watches rules that hold on every cycle:
- a sample is only ever produced on a strobe, and only while a word is being consumed;
- an underrun and a sample never fall in the same cycle;
- an underrun only happens on a strobe with no input word;
- a drop pulse never lasts longer than one cycle.

Several behaviours depend on the sample time and on the history of burst flags, so only the bench's scenarios can show them:
- the exact tick on which a held packet is released, including across a counter wrap;
- whether a packet is discarded or played;
- the full-rate flush of a late packet;
- which empty strobes count as underruns.

// File: rtl/tx_gate_pkg.sv
package tx_gate_pkg;

    // Controller states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STAMP,
        ST_HOLD,
        ST_PLAY,
        ST_FLUSH
    } gate_state_t;

    // Time comparison outcome
    typedef enum logic [1:0] {
        V_NOW,
        V_WAIT,
        V_LATE
    } verdict_t;

    // Header flag bit positions (decoded by the host side as well)
    localparam int FLAG_IMM = 2;
    localparam int FLAG_SOB = 1;
    localparam int FLAG_EOB = 0;

endpackage

// File: rtl/tx_time_judge.sv
module tx_time_judge
    import tx_gate_pkg::*;
#(
    parameter int TW = 32
) (
    input  logic [TW-1:0] pkt_time,
    input  logic [TW-1:0] cur_time,
    input  logic          force_now,
    output verdict_t      verdict,
    output logic          at_time
);
    localparam logic [TW-1:0] NOW_CODE = '1;

    logic [TW-1:0] delta;

    always_comb begin
        delta   = pkt_time - cur_time;
        at_time = (delta == '0);
        if (force_now || pkt_time == NOW_CODE || at_time) begin
            verdict = V_NOW;
        end else if (delta[TW-1]) begin
            verdict = V_LATE;
        end else begin
            verdict = V_WAIT;
        end
    end
endmodule

// File: rtl/tx_burst_track.sv
module tx_burst_track (
    input  logic clk,
    input  logic rst_n,
    input  logic open_evt,
    input  logic close_evt,
    output logic in_burst
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_burst <= 1'b0;
        end else if (close_evt) begin
            in_burst <= 1'b0;
        end else if (open_evt) begin
            in_burst <= 1'b1;
        end
    end
endmodule

// File: rtl/tx_release_gate.sv
module tx_release_gate
    import tx_gate_pkg::*;
#(
    parameter int DW = 32,
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] in_data,
    input  logic          in_valid,
    input  logic          in_sop,
    input  logic          in_eop,
    output logic          in_ready,
    input  logic [TW-1:0] now_time,
    input  logic          smp_strobe,
    output logic [DW-1:0] out_sample,
    output logic          out_valid,
    output logic          drop_pulse,
    output logic          underrun_pulse
);
    localparam int NFLAG = 3;

    gate_state_t      state_q, state_d;
    logic [NFLAG-1:0] flags_q;
    logic [TW-1:0]    ts_q;
    logic [TW-1:0]    ts_sel;
    verdict_t         verdict;
    logic             at_time;
    logic             take;
    logic             play_ok;
    logic             in_burst;
    logic             open_evt;
    logic             close_evt;

    assign ts_sel = (state_q == ST_STAMP) ? in_data[TW-1:0] : ts_q;
    assign take   = in_valid && in_ready;

    tx_time_judge #(.TW(TW)) u_judge (
        .pkt_time  (ts_sel),
        .cur_time  (now_time),
        .force_now ((state_q == ST_STAMP) && flags_q[FLAG_IMM]),
        .verdict   (verdict),
        .at_time   (at_time)
    );

    assign open_evt  = (state_q == ST_IDLE) && take && in_sop && in_data[FLAG_SOB];
    assign close_evt = (state_q != ST_IDLE) && take && in_eop && flags_q[FLAG_EOB];

    tx_burst_track u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_evt  (open_evt),
        .close_evt (close_evt),
        .in_burst  (in_burst)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Header and time capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            ts_q    <= '0;
        end else begin
            if (state_q == ST_IDLE && take && in_sop) begin
                flags_q <= in_data[NFLAG-1:0];
            end
            if (state_q == ST_STAMP && take) begin
                ts_q <= in_data[TW-1:0];
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take && in_sop) state_d = ST_STAMP;
            end
            ST_STAMP: begin
                if (take) begin
                    if (in_eop) begin
                        state_d = ST_IDLE;
                    end else begin
                        unique case (verdict)
                            V_NOW:   state_d = ST_PLAY;
                            V_WAIT:  state_d = ST_HOLD;
                            default: state_d = ST_FLUSH;
                        endcase
                    end
                end
            end
            ST_HOLD: begin
                if (verdict == V_LATE) begin
                    state_d = ST_FLUSH;
                end else if (at_time) begin
                    state_d = (take && in_eop) ? ST_IDLE : ST_PLAY;
                end
            end
            ST_PLAY, ST_FLUSH: begin
                if (take && in_eop) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        play_ok = (state_q == ST_PLAY) || (state_q == ST_HOLD && at_time);
        unique case (state_q)
            ST_HOLD:  in_ready = at_time && smp_strobe;
            ST_PLAY:  in_ready = smp_strobe;
            default:  in_ready = 1'b1;
        endcase
        out_sample     = in_data;
        out_valid      = play_ok && smp_strobe && in_valid;
        drop_pulse     = (state_q == ST_STAMP && take && !in_eop && verdict == V_LATE) ||
                         (state_q == ST_HOLD && verdict == V_LATE);
        underrun_pulse = smp_strobe && in_burst && !in_valid &&
                         (state_q == ST_IDLE || state_q == ST_STAMP || play_ok);
    end
endmodule

// File: rtl/tx_release_gate_chk.sv
module tx_release_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic smp_strobe,
    input logic in_valid,
    input logic in_ready,
    input logic out_valid,
    input logic drop_pulse,
    input logic underrun_pulse
);
    // R7
    sample_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> smp_strobe);

    // R7
    sample_consumes_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (in_valid && in_ready));

    // R4
    drop_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |=> !drop_pulse);

    // R8
    underrun_empty_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_pulse |-> (smp_strobe && !in_valid));

    // R8
    underrun_no_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_pulse |-> !out_valid);
endmodule

bind tx_release_gate tx_release_gate_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .smp_strobe     (smp_strobe),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .out_valid      (out_valid),
    .drop_pulse     (drop_pulse),
    .underrun_pulse (underrun_pulse)
);

// File: tb/sim_tx_release_gate.sv
`timescale 1ns/1ps
module sim_tx_release_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic        in_ready;
    logic [31:0] tnow = '0;
    logic        strb = 1'b0;
    logic [31:0] out_sample;
    logic        out_valid;
    logic        drop_pulse;
    logic        underrun_pulse;
    logic        ld = 1'b0;
    logic [31:0] ldv = '0;

    int checks = 0;
    int failures = 0;
    int samples, drops, unders, cyc_used, mism, nostrobe, pkt_id;
    logic [31:0] first_t;
    logic [31:0] base;
    bit got_first;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (ld) tnow <= ldv;
        else if (strb) tnow <= tnow + 32'd1;
    end

    tx_release_gate u0 (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_sop(in_sop), .in_eop(in_eop), .in_ready(in_ready), .now_time(tnow),
        .smp_strobe(strb), .out_sample(out_sample), .out_valid(out_valid),
        .drop_pulse(drop_pulse), .underrun_pulse(underrun_pulse)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_time(input logic [31:0] v);
        @(negedge clk);
        strb = 1'b0; ld = 1'b1; ldv = v;
        @(negedge clk);
        ld = 1'b0;
    endtask

    task automatic run_pkt(input logic [2:0] fl, input logic [31:0] ts, input int n,
                           input int per, input int gap_at, input int gap);
        int idx = 0;
        int last = n + 1;
        int gl = gap;
        int c = 0;
        int guard = 0;
        pkt_id++;
        base = 32'hA500_0000 | (pkt_id << 8);
        samples = 0; drops = 0; unders = 0; mism = 0; nostrobe = 0; got_first = 0;
        first_t = '0;
        while (idx <= last && guard < 3000) begin
            @(negedge clk);
            guard++;
            strb = ((c % per) == 0);
            c++;
            if (gap > 0 && gl > 0 && idx == gap_at + 2) begin
                in_valid = 1'b0; gl--;
            end else begin
                in_valid = 1'b1;
            end
            in_sop  = (idx == 0);
            in_eop  = (idx == last);
            in_data = (idx == 0) ? {29'd0, fl} : (idx == 1) ? ts : base + 32'(idx - 2);
            #1;
            if (out_valid) begin
                if (!got_first) begin got_first = 1; first_t = tnow; end
                if (!strb) nostrobe++;
                if (out_sample != base + 32'(samples)) mism++;
                samples++;
            end
            drops  += int'(drop_pulse);
            unders += int'(underrun_pulse);
            if (in_valid && in_ready) idx++;
        end
        cyc_used = guard;
        if (guard >= 3000) chk(0, "R2 packet timeout", guard, 0);
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; strb = 1'b0;
    endtask

    task automatic idle_cycles(input int k);
        unders = 0; samples = 0;
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            in_valid = 1'b0; strb = 1'b1;
            #1;
            unders  += int'(underrun_pulse);
            samples += int'(out_valid);
        end
        @(negedge clk);
        strb = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        chk(!out_valid && !drop_pulse && !underrun_pulse, "R1 outputs low after reset",
            {out_valid, drop_pulse, underrun_pulse}, 0);
        chk(in_ready, "R1 in_ready high after reset", in_ready, 1);
        strb = 1'b1;
        #1;
        chk(!underrun_pulse, "R1 no burst open after reset", underrun_pulse, 0);
        strb = 1'b0;
    endtask

    task automatic t_future_hold();
        set_time(32'd100);
        run_pkt(3'b000, 32'd130, 4, 1, 0, 0);
        chk(first_t == 32'd130, "R3 held release tick", first_t, 130);
        chk(samples == 4 && mism == 0, "R3 held packet samples", samples, 4);
        chk(drops == 0, "R3 held packet not dropped", drops, 0);
        set_time(32'd200);
        run_pkt(3'b000, 32'd230, 3, 2, 0, 0);
        chk(first_t == 32'd230, "R3 held release tick, slow strobe", first_t, 230);
    endtask

    task automatic t_wrap();
        set_time(32'hFFFF_FFF8);
        run_pkt(3'b000, 32'd4, 3, 1, 0, 0);
        chk(drops == 0, "R3 wrapped time is future", drops, 0);
        chk(first_t == 32'd4, "R3 wrapped release tick", first_t, 4);
    endtask

    task automatic t_late();
        set_time(32'd1000);
        run_pkt(3'b000, 32'd900, 4, 1, 0, 0);
        chk(drops == 1, "R4 late packet drop pulse", drops, 1);
        chk(samples == 0, "R4 late packet no samples", samples, 0);
        chk(cyc_used == 6, "R4 late packet full-rate flush", cyc_used, 6);
        set_time(32'd5000);
        run_pkt(3'b000, 32'd4000, 4, 3, 0, 0);
        chk(cyc_used == 6 && drops == 1, "R4 flush ignores strobe", cyc_used, 6);
    endtask

    task automatic t_now_code();
        set_time(32'd50);
        run_pkt(3'b000, 32'hFFFF_FFFF, 4, 1, 0, 0);
        chk(cyc_used == 6 && samples == 4 && mism == 0, "R5 all-ones plays at once", cyc_used, 6);
        chk(drops == 0, "R5 all-ones not dropped", drops, 0);
    endtask

    task automatic t_immediate();
        set_time(32'd7000);
        run_pkt(3'b100, 32'd10, 4, 1, 0, 0);
        chk(drops == 0, "R6 immediate past packet not dropped", drops, 0);
        chk(samples == 4 && mism == 0 && cyc_used == 6, "R6 immediate plays at once", samples, 4);
    endtask

    task automatic t_strobe_rate();
        run_pkt(3'b100, 32'd0, 5, 4, 0, 0);
        chk(samples == 5 && mism == 0, "R7 samples in order", samples, 5);
        chk(nostrobe == 0, "R7 no sample without strobe", nostrobe, 0);
    endtask

    task automatic t_bursts();
        run_pkt(3'b110, 32'hFFFF_FFFF, 4, 1, 1, 2);
        chk(unders == 2 && samples == 4 && mism == 0, "R8 underrun inside packet", unders, 2);
        idle_cycles(5);
        chk(unders == 5, "R8 underrun between packets of a burst", unders, 5);
        run_pkt(3'b101, 32'hFFFF_FFFF, 3, 1, 0, 0);
        chk(unders == 0 && samples == 3, "R2 end packet plays cleanly", unders, 0);
        idle_cycles(5);
        chk(unders == 0, "R9 no underrun after end of burst", unders, 0);
        run_pkt(3'b100, 32'hFFFF_FFFF, 4, 1, 1, 3);
        chk(unders == 0 && samples == 4, "R9 no underrun outside burst", unders, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired (all requirements) actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        pkt_id = 0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_future_hold();
        t_wrap();
        t_late();
        t_now_code();
        t_immediate();
        t_strobe_rate();
        t_bursts();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule